// File: doc/BRIEF.md
# DMA Channel Service Sequencer

This block decides which of four DMA channels gets the bus and then runs that channel's transfer. Each channel has a base address, a base count and a mode byte. It also has a request line and a mask bit. A channel can be served when its request is high, its mask bit is clear and its mode selects single-transfer operation. Among the channels that can be served, the lowest-numbered one wins.

For the granted channel, the sequencer asserts that channel's acknowledge. It presents a physical memory address built from the channel's high page, its page and its current address, together with a read or write qualifier. When the peripheral signals that the unit has moved, the sequencer advances the current address and count. The acknowledge then drops for at least one clock before the next grant.

The last unit of a block raises a one-clock terminal-count pulse and sets that channel's sticky terminal-count flag. An auto-initialising channel reloads its current values from its base values at that point. Any other channel has its mask bit set. A shift parameter scales the address and step size for a word-wide controller (0 for byte units, 1 for word units).

Top module: `dma_svc_seq`

## Requirements
- R1: A channel is eligible when dreq[i] is 1, mask_q[i] is 0 and its operating-mode field (mode bits [5:4] of that channel's 6-bit field) is 2'b01. The lowest-numbered eligible channel is granted, and ack is one-hot with that channel's bit.
- R2: A channel whose request is high and whose mask bit is clear, but whose operating-mode field is not 2'b01, is never granted. Its bad_mode bit reads 1 one clock after that condition is sampled.
- R3: While ack is high, mem_addr equals (high page << 24) | (page << 16) | current address, all three values belonging to the granted channel.
- R4: A page write with pg_off 7, 3, 1 or 2 targets channel 0, 1, 2 or 3 respectively. With pg_hi set, the write goes to the 7-bit high page and pg_data bit 7 is dropped. Writes with pg_off 0, 4, 5 or 6 change nothing.
- R5: Each completed unit moves the current address by 2^SHIFT. The address decrements when mode bit [3] is 1 and increments when it is 0, wrapping within the current-address width.
- R6: Transfer type is mode bits [1:0]. The value 2'b01 asserts mem_wr, 2'b10 asserts mem_rd, and 2'b00 or 2'b11 asserts neither. The count still advances in every case, and mem_rd and mem_wr are never high together.
- R7: A block is base count + 1 units long. Completing the unit taken when the current count is 0 gives tc_pulse high for exactly one clock and sets tc_flag[i].
- R8: When mode bit [2] is 1, terminal count reloads the current address (base << SHIFT) and the current count from the base values, and leaves the mask bit unchanged.
- R9: When mode bit [2] is 0, terminal count sets mask_q[i], so the channel is not granted again until it is unmasked.
- R10: ack rises the clock after the grant decision. It holds until xfer_ready is sampled high, then is 0 for at least one clock.
- R11: After reset, ack, mem_rd, mem_wr, tc_pulse, tc_flag and bad_mode are 0, and mask_q is all ones.
- R12: An init_ch[i] pulse loads channel i's current address (base_addr << SHIFT) and current count from its base values, and clears tc_flag[i]. msk_wr loads mask_q from msk_data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_addr | input | 4*CW | Per-channel base address, channel i at [i*CW +: CW] |
| base_cnt | input | 4*CW | Per-channel base count (units minus one) |
| mode | input | 4*6 | Per-channel mode: [5:4] operating mode, [3] decrement, [2] auto-init, [1:0] transfer type |
| init_ch | input | 4 | Per-channel pulse that loads current values from the base values |
| msk_wr | input | 1 | Load mask register |
| msk_data | input | 4 | New mask value |
| pg_wr | input | 1 | Page register write strobe |
| pg_hi | input | 1 | Selects the high page instead of the page |
| pg_off | input | 3 | Page register offset |
| pg_data | input | PGW | Page write data |
| dreq | input | 4 | Per-channel request |
| xfer_ready | input | 1 | Peripheral has completed the current unit |
| ack | output | 4 | Per-channel acknowledge, one-hot |
| mem_addr | output | 16+PGW+HPW | Physical memory address |
| mem_rd | output | 1 | Memory read qualifier |
| mem_wr | output | 1 | Memory write qualifier |
| tc_pulse | output | 1 | One-clock terminal-count pulse |
| tc_flag | output | 4 | Sticky per-channel terminal-count flags |
| mask_q | output | 4 | Current mask register |
| bad_mode | output | 4 | Per-channel unsupported-mode indication |

## Verification
A request raised while the sequencer is idle shows up as ack, mem_addr and the qualifiers one clock later. bad_mode is due in that same clock. After xfer_ready is sampled high, the next clock carries ack low, tc_pulse, the updated tc_flag and the updated mask_q. The following clock must show tc_pulse low again. The bench drives all inputs on the falling edge and samples on the next falling edge after each edge that produces a result, so every check lands in the exact cycle the requirement names.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  localparam int NCH = 4;
  localparam int MODE_W = 6;

  typedef enum logic [0:0] {ST_IDLE, ST_XFER} seq_state_t;

  localparam logic [1:0] OPM_SINGLE  = 2'b01;
  localparam logic [1:0] TT_TOMEM    = 2'b01;
  localparam logic [1:0] TT_FROMMEM  = 2'b10;

  // offset -> {valid, channel}
  function automatic logic [2:0] page_slot(input logic [2:0] off);
    case (off)
      3'd1:    page_slot = 3'b110;
      3'd2:    page_slot = 3'b111;
      3'd3:    page_slot = 3'b101;
      3'd7:    page_slot = 3'b100;
      default: page_slot = 3'b000;
    endcase
  endfunction
endpackage

// File: rtl/dma_page_file.sv
module dma_page_file
  import dma_seq_pkg::*;
#(
  parameter int PGW = 8,
  parameter int HPW = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr,
  input  logic               hi,
  input  logic [2:0]         off,
  input  logic [PGW-1:0]     data,
  output logic [NCH*PGW-1:0] pg,
  output logic [NCH*HPW-1:0] hp
);
  logic [2:0] slot;
  assign slot = page_slot(off);

  for (genvar i = 0; i < NCH; i++) begin : g_pg
    always_ff @(posedge clk) begin
      if (rst) begin
        pg[i*PGW +: PGW] <= '0;
        hp[i*HPW +: HPW] <= '0;
      end else if (wr && slot[2] && (slot[1:0] == 2'(i))) begin
        if (hi) hp[i*HPW +: HPW] <= data[HPW-1:0];
        else    pg[i*PGW +: PGW] <= data;
      end
    end
  end

  AST_PAGE_INVALID: assert property (@(posedge clk) disable iff (rst)
    (wr && !slot[2]) |=> ($stable(pg) && $stable(hp))); // R4
endmodule

// File: rtl/dma_prio_pick.sv
module dma_prio_pick #(
  parameter int N = 4
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant,
  output logic         any
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;
  for (genvar i = 0; i < N; i++) begin : g_chain
    assign grant[i]  = req[i] & ~seen[i];
    assign seen[i+1] = seen[i] | req[i];
  end
  assign any = seen[N];
endmodule

// File: rtl/dma_chan_ctr.sv
module dma_chan_ctr #(
  parameter int CW    = 16,
  parameter int SHIFT = 0,
  localparam int AW   = CW + SHIFT
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          init,
  input  logic [CW-1:0] base_addr,
  input  logic [CW-1:0] base_cnt,
  input  logic          step,
  input  logic          dec,
  input  logic          autoinit,
  output logic [AW-1:0] cur_addr,
  output logic          last
);
  localparam logic [AW-1:0] STEP = AW'(1) << SHIFT;
  logic [CW-1:0] cur_cnt;

  assign last = (cur_cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_addr <= '0;
      cur_cnt  <= '0;
    end else if (init) begin
      cur_addr <= AW'(base_addr) << SHIFT;
      cur_cnt  <= base_cnt;
    end else if (step) begin
      if (last && autoinit) begin
        cur_addr <= AW'(base_addr) << SHIFT;
        cur_cnt  <= base_cnt;
      end else begin
        cur_addr <= dec ? cur_addr - STEP : cur_addr + STEP;
        cur_cnt  <= cur_cnt - 1'b1;
      end
    end
  end

  AST_AUTO_RELOAD: assert property (@(posedge clk) disable iff (rst)
    (step && !init && last && autoinit) |=> (cur_cnt == $past(base_cnt))); // R8
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    (step && !init && !(last && autoinit)) |=>
      (cur_addr == ($past(dec) ? $past(cur_addr) - STEP : $past(cur_addr) + STEP))); // R5
endmodule

// File: rtl/dma_svc_seq.sv
module dma_svc_seq
  import dma_seq_pkg::*;
#(
  parameter int SHIFT = 0,
  parameter int CW    = 16,
  parameter int PGW   = 8,
  parameter int HPW   = 7,
  localparam int AW   = CW + SHIFT,
  localparam int PA_W = 16 + PGW + HPW
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NCH*CW-1:0]     base_addr,
  input  logic [NCH*CW-1:0]     base_cnt,
  input  logic [NCH*MODE_W-1:0] mode,
  input  logic [NCH-1:0]        init_ch,
  input  logic                  msk_wr,
  input  logic [NCH-1:0]        msk_data,
  input  logic                  pg_wr,
  input  logic                  pg_hi,
  input  logic [2:0]            pg_off,
  input  logic [PGW-1:0]        pg_data,
  input  logic [NCH-1:0]        dreq,
  input  logic                  xfer_ready,
  output logic [NCH-1:0]        ack,
  output logic [PA_W-1:0]       mem_addr,
  output logic                  mem_rd,
  output logic                  mem_wr,
  output logic                  tc_pulse,
  output logic [NCH-1:0]        tc_flag,
  output logic [NCH-1:0]        mask_q,
  output logic [NCH-1:0]        bad_mode
);
  localparam int IW = $clog2(NCH);

  seq_state_t state;
  logic [IW-1:0] gch, pick_idx;
  logic [NCH*PGW-1:0] pg_flat;
  logic [NCH*HPW-1:0] hp_flat;
  logic [NCH-1:0] elig, bad_now, grant_w, step, last_w, auto_w;
  logic any_w;
  logic [AW-1:0] cur_a [NCH];

  dma_page_file #(.PGW(PGW), .HPW(HPW)) u_pages (
    .clk(clk), .rst(rst), .wr(pg_wr), .hi(pg_hi), .off(pg_off),
    .data(pg_data), .pg(pg_flat), .hp(hp_flat));

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [MODE_W-1:0] md;
    assign md         = mode[i*MODE_W +: MODE_W];
    assign elig[i]    = dreq[i] & ~mask_q[i] & (md[5:4] == OPM_SINGLE);
    assign bad_now[i] = dreq[i] & ~mask_q[i] & (md[5:4] != OPM_SINGLE);
    assign auto_w[i]  = md[2];
    assign step[i]    = (state == ST_XFER) & xfer_ready & ack[i];

    dma_chan_ctr #(.CW(CW), .SHIFT(SHIFT)) u_ctr (
      .clk(clk), .rst(rst), .init(init_ch[i]),
      .base_addr(base_addr[i*CW +: CW]), .base_cnt(base_cnt[i*CW +: CW]),
      .step(step[i]), .dec(md[3]), .autoinit(md[2]),
      .cur_addr(cur_a[i]), .last(last_w[i]));

    AST_TC_MASKS: assert property (@(posedge clk) disable iff (rst)
      (step[i] && last_w[i] && !auto_w[i]) |=> mask_q[i]); // R9
  end

  dma_prio_pick #(.N(NCH)) u_pick (.req(elig), .grant(grant_w), .any(any_w));

  always_comb begin
    pick_idx = '0;
    for (int i = 0; i < NCH; i++)
      if (grant_w[i]) pick_idx = IW'(i);
  end

  logic [1:0] pick_tt;
  assign pick_tt = mode[32'(pick_idx)*MODE_W +: 2];

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      ack      <= '0;
      gch      <= '0;
      mem_addr <= '0;
      mem_rd   <= 1'b0;
      mem_wr   <= 1'b0;
      tc_pulse <= 1'b0;
      bad_mode <= '0;
    end else begin
      tc_pulse <= 1'b0;
      bad_mode <= bad_now;
      case (state)
        ST_IDLE: if (any_w) begin
          state    <= ST_XFER;
          ack      <= grant_w;
          gch      <= pick_idx;
          mem_addr <= (PA_W'({hp_flat[32'(pick_idx)*HPW +: HPW],
                              pg_flat[32'(pick_idx)*PGW +: PGW]}) << 16)
                      | PA_W'(cur_a[pick_idx]);
          mem_rd   <= (pick_tt == TT_FROMMEM);
          mem_wr   <= (pick_tt == TT_TOMEM);
        end
        ST_XFER: if (xfer_ready) begin
          state    <= ST_IDLE;
          ack      <= '0;
          mem_rd   <= 1'b0;
          mem_wr   <= 1'b0;
          tc_pulse <= last_w[gch];
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= '1;
      tc_flag <= '0;
    end else begin
      if (msk_wr) mask_q <= msk_data;
      for (int i = 0; i < NCH; i++) begin
        if (step[i] && last_w[i]) begin
          tc_flag[i] <= 1'b1;
          if (!auto_w[i]) mask_q[i] <= 1'b1;
        end
        if (init_ch[i]) tc_flag[i] <= 1'b0;
      end
    end
  end

  AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ack)); // R10
  AST_ACK_GAP: assert property (@(posedge clk) disable iff (rst)
    ((|ack) && xfer_ready) |=> (ack == '0)); // R10
  AST_ACCESS_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr)); // R6
  AST_ACCESS_UNDER_ACK: assert property (@(posedge clk) disable iff (rst)
    (mem_rd || mem_wr) |-> (|ack)); // R6
  AST_TC_SINGLE: assert property (@(posedge clk) disable iff (rst)
    tc_pulse |=> !tc_pulse); // R7
endmodule

// File: tb/dma_svc_seq_test.sv
`timescale 1ns/1ps
module dma_svc_seq_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [63:0] base_addr = '0, base_cnt = '0;
  logic [23:0] mode = '0;
  logic [3:0]  init_ch = '0, msk_data = '0, dreq = '0;
  logic msk_wr = 0, pg_wr = 0, pg_hi = 0, xfer_ready = 0;
  logic [2:0] pg_off = '0;
  logic [7:0] pg_data = '0;
  logic [3:0] ack, tc_flag, mask_q, bad_mode;
  logic [30:0] mem_addr;
  logic mem_rd, mem_wr, tc_pulse;

  dma_svc_seq uut (
    .clk(clk), .rst(rst), .base_addr(base_addr), .base_cnt(base_cnt),
    .mode(mode), .init_ch(init_ch), .msk_wr(msk_wr), .msk_data(msk_data),
    .pg_wr(pg_wr), .pg_hi(pg_hi), .pg_off(pg_off), .pg_data(pg_data),
    .dreq(dreq), .xfer_ready(xfer_ready), .ack(ack), .mem_addr(mem_addr),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .tc_pulse(tc_pulse), .tc_flag(tc_flag),
    .mask_q(mask_q), .bad_mode(bad_mode));

  always #10 clk = ~clk;

  int n_chk = 0, n_err = 0;
  logic [15:0] m_ba [4], m_bc [4], m_ca [4], m_cc [4];
  logic [5:0]  m_md [4];
  logic [7:0]  m_pg [4];
  logic [6:0]  m_hp [4];
  logic [3:0]  m_mask, m_tcf;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [30:0] exp_addr(input int ch);
    return {m_hp[ch], m_pg[ch], 16'h0} | {15'h0, m_ca[ch]};
  endfunction

  task automatic cfg(input int ch, input logic [15:0] a, input logic [15:0] c, input logic [5:0] md);
    base_addr[ch*16 +: 16] = a;
    base_cnt[ch*16 +: 16]  = c;
    mode[ch*6 +: 6]        = md;
    init_ch = 4'(1 << ch);
    @(negedge clk);
    init_ch = '0;
    m_ba[ch] = a; m_bc[ch] = c; m_md[ch] = md; m_ca[ch] = a; m_cc[ch] = c;
    m_tcf[ch] = 1'b0;
    check("R12 init clears tc flag", 64'(tc_flag), 64'(m_tcf));
  endtask

  task automatic wmask(input logic [3:0] m);
    msk_wr = 1; msk_data = m;
    @(negedge clk);
    msk_wr = 0;
    m_mask = m;
    check("R12 mask load", 64'(mask_q), 64'(m_mask));
  endtask

  task automatic wpage(input logic [2:0] off, input logic hi, input logic [7:0] d);
    pg_wr = 1; pg_hi = hi; pg_off = off; pg_data = d;
    @(negedge clk);
    pg_wr = 0;
    case (off)
      3'd7: if (hi) m_hp[0] = d[6:0]; else m_pg[0] = d;
      3'd3: if (hi) m_hp[1] = d[6:0]; else m_pg[1] = d;
      3'd1: if (hi) m_hp[2] = d[6:0]; else m_pg[2] = d;
      3'd2: if (hi) m_hp[3] = d[6:0]; else m_pg[3] = d;
      default: ;
    endcase
  endtask

  task automatic service(input logic [3:0] req, input int stall);
    logic [3:0] elig, badv;
    int win;
    logic tcexp;
    logic [15:0] stp;
    dreq = req;
    @(negedge clk);
    elig = '0; badv = '0;
    for (int i = 0; i < 4; i++) begin
      if (req[i] && !m_mask[i]) begin
        if (m_md[i][5:4] == 2'b01) elig[i] = 1'b1;
        else badv[i] = 1'b1;
      end
    end
    check("R2 bad mode flag", 64'(bad_mode), 64'(badv));
    if (elig == 0) begin
      check("R1 no eligible channel", 64'(ack), 64'h0);
      @(negedge clk);
      check("R9/R2 still no grant", 64'(ack), 64'h0);
      dreq = '0;
      @(negedge clk);
      return;
    end
    win = 0;
    for (int i = 3; i >= 0; i--) if (elig[i]) win = i;
    check("R1 fixed priority grant", 64'(ack), 64'(1 << win));
    check("R3 memory address", 64'(mem_addr), 64'(exp_addr(win)));
    check("R6 read qualifier", 64'(mem_rd), 64'(m_md[win][1:0] == 2'b10));
    check("R6 write qualifier", 64'(mem_wr), 64'(m_md[win][1:0] == 2'b01));
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      check("R10 ack held while waiting", 64'(ack), 64'(1 << win));
    end
    xfer_ready = 1;
    @(negedge clk);
    xfer_ready = 0;
    dreq = '0;
    tcexp = (m_cc[win] == 16'h0);
    stp = m_md[win][3] ? 16'hFFFF : 16'h0001;
    if (tcexp) begin
      m_tcf[win] = 1'b1;
      if (m_md[win][2]) begin
        m_ca[win] = m_ba[win]; m_cc[win] = m_bc[win];
      end else begin
        m_mask[win] = 1'b1;
        m_ca[win] = m_ca[win] + stp; m_cc[win] = 16'hFFFF;
      end
    end else begin
      m_ca[win] = m_ca[win] + stp; m_cc[win] = m_cc[win] - 1'b1;
    end
    check("R10 ack gap", 64'(ack), 64'h0);
    check("R7 terminal count pulse", 64'(tc_pulse), 64'(tcexp));
    check("R7 terminal count flags", 64'(tc_flag), 64'(m_tcf));
    check("R9 R8 mask after transfer", 64'(mask_q), 64'(m_mask));
    @(negedge clk);
    check("R7 pulse lasts one clock", 64'(tc_pulse), 64'h0);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 4; i++) begin
      m_ba[i] = 0; m_bc[i] = 0; m_ca[i] = 0; m_cc[i] = 0;
      m_md[i] = 0; m_pg[i] = 0; m_hp[i] = 0;
    end
    m_mask = 4'hF; m_tcf = 4'h0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R11 reset ack", 64'(ack), 64'h0);
    check("R11 reset mask", 64'(mask_q), 64'hF);
    check("R11 reset flags", 64'({tc_flag, bad_mode, tc_pulse, mem_rd, mem_wr}), 64'h0);

    // page map, including the dropped bit of the high page and invalid offsets
    wpage(3'd7, 0, 8'h10); wpage(3'd3, 0, 8'h31); wpage(3'd1, 0, 8'h52); wpage(3'd2, 0, 8'h73);
    wpage(3'd7, 1, 8'hFF); wpage(3'd3, 1, 8'h11); wpage(3'd1, 1, 8'h22); wpage(3'd2, 1, 8'h33);
    wpage(3'd0, 0, 8'hEE); wpage(3'd4, 1, 8'hEE); wpage(3'd5, 0, 8'hEE); wpage(3'd6, 1, 8'hEE);

    cfg(0, 16'h1000, 16'h0003, 6'b01_0_0_01);
    cfg(1, 16'h0000, 16'h0001, 6'b01_1_0_00);
    cfg(2, 16'h2000, 16'h0000, 6'b01_0_1_10);
    cfg(3, 16'h3000, 16'h0005, 6'b10_0_0_01);
    wmask(4'h0);
    service(4'hF, 0);   // R1 channel 0 wins, R4 high page 0x7F
    service(4'hE, 1);   // channel 1, verify at address 0
    service(4'h2, 0);   // R5 decrement wraps to FFFF, R9 terminal count masks ch1
    service(4'h2, 0);   // R9 masked: no grant
    service(4'h4, 2);   // R8 auto-init terminal count
    service(4'h4, 0);   // R8 reload seen at same address
    service(4'h8, 0);   // R2 bad operating mode never granted
    cfg(1, 16'h0040, 16'h0002, 6'b01_0_0_10);  // R12 clears flag
    wmask(4'h0);
    service(4'h2, 0);

    for (int it = 0; it < 600; it++) begin
      int k;
      k = int'($urandom % 10);
      if (k == 0) begin
        logic [1:0] opm;
        opm = ($urandom % 8 == 0) ? 2'b10 : 2'b01;
        cfg(int'($urandom % 4), 16'($urandom), 16'($urandom % 4),
            {opm, 1'($urandom), 1'($urandom), 2'($urandom)});
      end else if (k == 1) begin
        wmask(4'($urandom));
      end else if (k == 2) begin
        wpage(3'($urandom), 1'($urandom), 8'($urandom));
      end else begin
        service(4'($urandom), int'($urandom % 3));
      end
    end
    finish_run();
  end
endmodule